// File: doc/BRIEF.md
# GPIO Port Group Pin Configuration and Function Mux

This block is one group of general-purpose I/O pins, up to 32 of them, seen by software through a small register bus. Each pin owns an 8-bit configuration byte. The byte picks who controls the pad: the group's own direction and output-level registers, or one of sixteen peripheral function slots chosen by that pin's 4-bit function select. The same byte also gates input sampling, turns on the pull resistor, selects open-drain operation, and carries drive-strength and slew-limit codes out to the pad.

Software writes the direction, output-level, function-select and configuration registers. Peripherals present an output-enable and an output value per pin for every function slot. The block forwards the selected pair to the pad, samples the pad inputs into an input register and returns everything through registered reads. Function-select codes 0xD and 0xE are reserved; a pin handed to one of them is parked as an input and does not drive. The slew field exists only on pins named in a parameter mask.

Address decode is a one-hot region classification with six named outcomes: direction, output level, input, function select, pin configuration and unmapped. Each pad source is a three-way choice: port control, peripheral control or parked.

Top module: `gpio_port_group`

## Requirements
- R1: After reset every configuration byte, function select, direction bit and output bit is zero. As a result every pad_oe, pad_out and pad_pull_en bit is 0, and reads of all registers return 0.
- R2: Pin n's configuration byte sits at byte address 0x40+n and reads back what was written. Its fields are: bit 0 mux enable, bit 1 input enable, bit 2 pull enable, bit 3 open-drain, bits 5:4 slew code, bits 7:6 drive code. Open-drain appears on pad_odrain[n] and the drive code on pad_drive[2n+1:2n].
- R3: With mux enable 0, pad_oe[n] equals bit n of the direction register (address 0x00) and pad_out[n] equals bit n of the output register (address 0x04). The pin's function select has no effect.
- R4: With mux enable 1, pad_oe[n] and pad_out[n] follow periph_oe[16n+s] and periph_out[16n+s]. Here s is the function select of pin n, held in bits 3:0 at address 0x20+n, for any non-reserved code (0x0 to 0xC, 0xF).
- R5: pad_pull_en[n] is 1 only when the pull bit is set and pad_oe[n] is 0 (pin acting as input).
- R6: The input register (address 0x08) bit n holds pad_in[n] as sampled on the previous clock edge when input enable is 1. It holds 0 when input enable is 0, whatever the pin direction.
- R7: A pin under peripheral control (mux enable 1) with input enable 1 still shows its pad level in the input register.
- R8: Slew codes 0 to 3 written to pins in the SLEW_MASK parameter appear on pad_slew[2n+1:2n] and read back. On other pins, writes to bits 5:4 are discarded, and both readback and pad_slew show 0.
- R9: With mux enable 1 and function select 0xD or 0xE, pad_oe[n] and pad_out[n] are both 0 regardless of the peripheral lines.
- R10: Writes to configuration or select addresses of pins at or beyond NPIN, and to unmapped addresses, change nothing. Reads there return 0.
- R11: bus_rdata is registered. It shows the data for the address presented in the previous cycle and holds the earlier result until the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 8 | Register byte address |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write enable |
| bus_rdata | output | 32 | Registered read data |
| periph_oe | input | NPIN*16 | Peripheral output enables, index 16*pin+function |
| periph_out | input | NPIN*16 | Peripheral output values, index 16*pin+function |
| pad_in | input | NPIN | Pad input levels |
| pad_oe | output | NPIN | Pad output enable |
| pad_out | output | NPIN | Pad output level |
| pad_pull_en | output | NPIN | Pull resistor enable |
| pad_odrain | output | NPIN | Open-drain enable |
| pad_slew | output | NPIN*2 | Slew code per pin |
| pad_drive | output | NPIN*2 | Drive-strength code per pin |

## Verification
The pad-source choice is tried with mux enable clear while a live function select is present, which tells port control apart from a mux that leaks the select. It is also tried with mux enable set across several select codes whose peripheral lines differ, including the top codes 0xC and 0xF. The reserved codes 0xD and 0xE are driven with all peripheral lines high, which separates parking from plain forwarding. Input sampling is tried with pad_in all ones against pins with and without input enable, and again under peripheral control. Slew writes go to a masked pin and an unmasked pin, which tells field gating apart from a plain byte store.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

    localparam int FN_SLOTS  = 16;
    localparam int SEL_W     = 4;
    localparam int CFG_W     = 8;
    localparam int ADDR_W    = 8;
    localparam int DATA_W    = 32;

    localparam logic [ADDR_W-1:0] ADR_DIR = 8'h00;
    localparam logic [ADDR_W-1:0] ADR_OUT = 8'h04;
    localparam logic [ADDR_W-1:0] ADR_IN  = 8'h08;

    typedef struct packed {
        logic [1:0] drive;
        logic [1:0] slew;
        logic       odrain;
        logic       pull;
        logic       inen;
        logic       muxen;
    } pin_cfg_t;

    typedef enum logic [2:0] {
        RG_NONE,
        RG_DIR,
        RG_OUT,
        RG_IN,
        RG_SEL,
        RG_CFG
    } reg_region_e;

    typedef enum logic [1:0] {
        SRC_PORT,
        SRC_PERIPH,
        SRC_PARK
    } drive_src_e;

    function automatic logic sel_reserved(input logic [SEL_W-1:0] s);
        return (s == 4'hD) || (s == 4'hE);
    endfunction

endpackage

// File: rtl/gpio_addr_decode.sv
module gpio_addr_decode #(
    parameter int NPIN = 32
) (
    input  logic [gpio_pkg::ADDR_W-1:0] addr,
    output gpio_pkg::reg_region_e       region,
    output logic [4:0]                  idx
);
    import gpio_pkg::*;

    reg_region_e raw;

    always_comb begin
        raw = RG_NONE;
        idx = addr[4:0];
        unique case (addr[7:5])
            3'b000: begin
                if (addr == ADR_DIR)      raw = RG_DIR;
                else if (addr == ADR_OUT) raw = RG_OUT;
                else if (addr == ADR_IN)  raw = RG_IN;
                else                      raw = RG_NONE;
            end
            3'b001:  raw = RG_SEL;
            3'b010:  raw = RG_CFG;
            default: raw = RG_NONE;
        endcase
    end

    always_comb begin
        region = raw;
        if ((raw == RG_SEL || raw == RG_CFG) && (32'(idx) >= NPIN))
            region = RG_NONE;
    end

endmodule

// File: rtl/gpio_cfg_regs.sv
module gpio_cfg_regs #(
    parameter int          NPIN      = 32,
    parameter logic [31:0] SLEW_MASK = 32'hC020_001F
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  gpio_pkg::reg_region_e         region,
    input  logic [4:0]                    idx,
    input  logic [gpio_pkg::DATA_W-1:0]   wdata,
    input  logic                          we,
    input  logic [NPIN-1:0]               pad_in,
    output logic [gpio_pkg::DATA_W-1:0]   rdata,
    output logic [NPIN*8-1:0]             cfg_flat,
    output logic [NPIN*4-1:0]             sel_flat,
    output logic [NPIN-1:0]               dir_o,
    output logic [NPIN-1:0]               out_o
);
    import gpio_pkg::*;

    localparam int IDX_W = (NPIN > 1) ? $clog2(NPIN) : 1;

    logic [CFG_W-1:0] cfg_q [NPIN];
    logic [SEL_W-1:0] sel_q [NPIN];
    logic [NPIN-1:0]  dir_q;
    logic [NPIN-1:0]  out_q;
    logic [NPIN-1:0]  in_q;
    logic [NPIN-1:0]  inen_vec;
    logic [DATA_W-1:0] rd_next;
    logic [IDX_W-1:0] pidx;
    logic [CFG_W-1:0] cfg_wr;

    assign pidx = idx[IDX_W-1:0];

    always_comb begin
        cfg_wr = wdata[CFG_W-1:0];
        if (!SLEW_MASK[idx]) cfg_wr[5:4] = 2'b00;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q <= '0;
            out_q <= '0;
            for (int i = 0; i < NPIN; i++) begin
                cfg_q[i] <= '0;
                sel_q[i] <= '0;
            end
        end else if (we) begin
            unique case (region)
                RG_DIR:  dir_q       <= wdata[NPIN-1:0];
                RG_OUT:  out_q       <= wdata[NPIN-1:0];
                RG_SEL:  sel_q[pidx] <= wdata[SEL_W-1:0];
                RG_CFG:  cfg_q[pidx] <= cfg_wr;
                RG_IN, RG_NONE: ;
                default: ;
            endcase
        end
    end

    generate
        for (genvar g = 0; g < NPIN; g++) begin : g_flat
            assign cfg_flat[g*8 +: 8] = cfg_q[g];
            assign sel_flat[g*4 +: 4] = sel_q[g];
            assign inen_vec[g]        = cfg_q[g][1];
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) in_q <= '0;
        else        in_q <= pad_in & inen_vec;
    end

    always_comb begin
        rd_next = '0;
        unique case (region)
            RG_DIR:  rd_next = 32'(dir_q);
            RG_OUT:  rd_next = 32'(out_q);
            RG_IN:   rd_next = 32'(in_q);
            RG_SEL:  rd_next = 32'(sel_q[pidx]);
            RG_CFG:  rd_next = 32'(cfg_q[pidx]);
            RG_NONE: rd_next = '0;
            default: rd_next = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rdata <= '0;
        else        rdata <= rd_next;
    end

    assign dir_o = dir_q;
    assign out_o = out_q;

    // R6: a pin whose input enable was clear never shows a sampled level
    a_r6_in_gated: assert property (@(posedge clk) disable iff (!rst_n)
        (in_q & ~$past(inen_vec)) == '0);

    // R10: an unmapped or out-of-range address reads back as zero
    a_r10_oob_read: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(region) == RG_NONE) |-> (rdata == '0));

    // R8: slew bits never reach storage on pins without the field
    generate
        for (genvar g = 0; g < NPIN; g++) begin : g_slew_chk
            a_r8_slew_store: assert property (@(posedge clk) disable iff (!rst_n)
                SLEW_MASK[g] || (cfg_q[g][5:4] == 2'b00));
        end
    endgenerate

endmodule

// File: rtl/gpio_pin_mux.sv
module gpio_pin_mux (
    input  logic                          muxen,
    input  logic [gpio_pkg::SEL_W-1:0]    sel,
    input  logic                          dir_bit,
    input  logic                          out_bit,
    input  logic                          pull_bit,
    input  logic [gpio_pkg::FN_SLOTS-1:0] fn_oe,
    input  logic [gpio_pkg::FN_SLOTS-1:0] fn_out,
    output logic                          oe,
    output logic                          out,
    output logic                          pull_en
);
    import gpio_pkg::*;

    drive_src_e src;

    always_comb begin
        if (!muxen)                 src = SRC_PORT;
        else if (sel_reserved(sel)) src = SRC_PARK;
        else                        src = SRC_PERIPH;
    end

    always_comb begin
        oe  = 1'b0;
        out = 1'b0;
        unique case (src)
            SRC_PORT: begin
                oe  = dir_bit;
                out = out_bit;
            end
            SRC_PERIPH: begin
                oe  = fn_oe[sel];
                out = fn_out[sel];
            end
            SRC_PARK: begin
                oe  = 1'b0;
                out = 1'b0;
            end
            default: begin
                oe  = 1'b0;
                out = 1'b0;
            end
        endcase
        pull_en = pull_bit & ~oe;
    end

endmodule

// File: rtl/gpio_port_group.sv
module gpio_port_group #(
    parameter int          NPIN      = 32,
    parameter logic [31:0] SLEW_MASK = 32'hC020_001F
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [7:0]           bus_addr,
    input  logic [31:0]          bus_wdata,
    input  logic                 bus_we,
    output logic [31:0]          bus_rdata,
    input  logic [NPIN*16-1:0]   periph_oe,
    input  logic [NPIN*16-1:0]   periph_out,
    input  logic [NPIN-1:0]      pad_in,
    output logic [NPIN-1:0]      pad_oe,
    output logic [NPIN-1:0]      pad_out,
    output logic [NPIN-1:0]      pad_pull_en,
    output logic [NPIN-1:0]      pad_odrain,
    output logic [NPIN*2-1:0]    pad_slew,
    output logic [NPIN*2-1:0]    pad_drive
);
    import gpio_pkg::*;

    reg_region_e        region;
    logic [4:0]         idx;
    logic [NPIN*8-1:0]  cfg_flat;
    logic [NPIN*4-1:0]  sel_flat;
    logic [NPIN-1:0]    dir_v;
    logic [NPIN-1:0]    out_v;

    gpio_addr_decode #(.NPIN(NPIN)) u_dec (
        .addr   (bus_addr),
        .region (region),
        .idx    (idx)
    );

    gpio_cfg_regs #(.NPIN(NPIN), .SLEW_MASK(SLEW_MASK)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .region   (region),
        .idx      (idx),
        .wdata    (bus_wdata),
        .we       (bus_we),
        .pad_in   (pad_in),
        .rdata    (bus_rdata),
        .cfg_flat (cfg_flat),
        .sel_flat (sel_flat),
        .dir_o    (dir_v),
        .out_o    (out_v)
    );

    generate
        for (genvar p = 0; p < NPIN; p++) begin : g_pin
            pin_cfg_t c;
            assign c = pin_cfg_t'(cfg_flat[p*8 +: 8]);

            gpio_pin_mux u_mux (
                .muxen    (c.muxen),
                .sel      (sel_flat[p*4 +: 4]),
                .dir_bit  (dir_v[p]),
                .out_bit  (out_v[p]),
                .pull_bit (c.pull),
                .fn_oe    (periph_oe[p*16 +: 16]),
                .fn_out   (periph_out[p*16 +: 16]),
                .oe       (pad_oe[p]),
                .out      (pad_out[p]),
                .pull_en  (pad_pull_en[p])
            );

            assign pad_odrain[p]      = c.odrain;
            assign pad_slew[p*2 +: 2] = c.slew;
            assign pad_drive[p*2 +: 2] = c.drive;

            // R5: pull resistor only on a pin that is not driving
            a_r5_pull_input: assert property (@(posedge clk) disable iff (!rst_n)
                !(pad_pull_en[p] && pad_oe[p]));

            // R9: reserved function codes never drive the pad
            a_r9_rsvd_park: assert property (@(posedge clk) disable iff (!rst_n)
                (c.muxen && sel_reserved(sel_flat[p*4 +: 4])) |-> (!pad_oe[p] && !pad_out[p]));

            // R8: pins without the slew field present the fast code
            a_r8_slew_pad: assert property (@(posedge clk) disable iff (!rst_n)
                SLEW_MASK[p] || (pad_slew[p*2 +: 2] == 2'b00));
        end
    endgenerate

endmodule

// File: tb/gpio_port_group_bench.sv
module gpio_port_group_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NPIN = 24;
    localparam logic [31:0] MASK = 32'h0020_001F;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic        we = 1'b0;
    logic [31:0] rdata;
    logic [NPIN*16-1:0] p_oe = '0;
    logic [NPIN*16-1:0] p_out = '0;
    logic [NPIN-1:0] pin = '0;
    logic [NPIN-1:0] oe, po, pull, od;
    logic [NPIN*2-1:0] slew, drive;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_port_group #(.NPIN(NPIN), .SLEW_MASK(MASK)) u_gpio_port_group (
        .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wdata(wdata),
        .bus_we(we), .bus_rdata(rdata), .periph_oe(p_oe), .periph_out(p_out),
        .pad_in(pin), .pad_oe(oe), .pad_out(po), .pad_pull_en(pull),
        .pad_odrain(od), .pad_slew(slew), .pad_drive(drive)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; we = 1'b1;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a;
        @(negedge clk);
        d = rdata;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        check("R1 pad_oe", 32'(oe), 0);
        check("R1 pad_out", 32'(po), 0);
        check("R1 pull", 32'(pull), 0);
        rd(8'h00, v); check("R1 dir", v, 0);
        rd(8'h04, v); check("R1 out", v, 0);
        rd(8'h40, v); check("R1 cfg0", v, 0);
        rd(8'h20, v); check("R1 sel0", v, 0);
    endtask

    task automatic t_cfg_layout();
        logic [31:0] v;
        wr(8'h43, 32'hC8);
        rd(8'h43, v); check("R2 readback", v, 32'hC8);
        check("R2 drive", 32'(drive[7:6]), 3);
        check("R2 odrain", 32'(od[3]), 1);
        check("R2 odrain other", 32'(od[4]), 0);
        wr(8'h43, 32'h00);
    endtask

    task automatic t_port_mode();
        wr(8'h22, 32'h9);
        p_oe[2*16+9] = 1'b0; p_out[2*16+9] = 1'b0;
        wr(8'h00, 32'h4);
        wr(8'h04, 32'h4);
        check("R3 oe from dir", 32'(oe[2]), 1);
        check("R3 out from out", 32'(po[2]), 1);
        wr(8'h00, 32'h0);
        check("R3 oe dir clear", 32'(oe[2]), 0);
    endtask

    task automatic t_periph_mode();
        p_oe[5*16+3] = 1'b1; p_out[5*16+3] = 1'b1;
        p_oe[5*16+7] = 1'b0; p_out[5*16+7] = 1'b1;
        p_oe[5*16+12] = 1'b1; p_out[5*16+12] = 1'b0;
        p_oe[5*16+15] = 1'b1; p_out[5*16+15] = 1'b1;
        wr(8'h04, 32'h0);
        wr(8'h25, 32'h3);
        wr(8'h45, 32'h01);
        check("R4 sel3 oe", 32'(oe[5]), 1);
        check("R4 sel3 out", 32'(po[5]), 1);
        wr(8'h25, 32'h7);
        check("R4 sel7 oe", 32'(oe[5]), 0);
        check("R4 sel7 out", 32'(po[5]), 1);
        wr(8'h25, 32'hC);
        check("R4 selC oe", 32'(oe[5]), 1);
        check("R4 selC out", 32'(po[5]), 0);
        wr(8'h25, 32'hF);
        check("R4 selF out", 32'(po[5]), 1);
    endtask

    task automatic t_pull();
        wr(8'h47, 32'h04);
        check("R5 pull as input", 32'(pull[7]), 1);
        wr(8'h00, 32'h80);
        check("R5 pull while driving", 32'(pull[7]), 0);
        wr(8'h00, 32'h0);
        wr(8'h47, 32'h0);
    endtask

    task automatic t_input_gate();
        logic [31:0] v;
        wr(8'h41, 32'h02);
        wr(8'h40, 32'h00);
        @(negedge clk); pin = '1;
        rd(8'h08, v); check("R6 inen set/clear", v & 32'h3, 32'h2);
        wr(8'h00, 32'h3);
        rd(8'h08, v); check("R6 gated as output", v & 32'h3, 32'h2);
        wr(8'h00, 32'h0);
        @(negedge clk); pin = '0;
        rd(8'h08, v); check("R6 low level", v & 32'h3, 0);
    endtask

    task automatic t_mux_readback();
        logic [31:0] v;
        wr(8'h45, 32'h03);
        @(negedge clk); pin[5] = 1'b1;
        rd(8'h08, v); check("R7 periph readback", 32'(v[5]), 1);
        @(negedge clk); pin[5] = 1'b0;
        wr(8'h45, 32'h00);
    endtask

    task automatic t_slew();
        logic [31:0] v;
        wr(8'h55, 32'h30);
        rd(8'h55, v); check("R8 masked pin readback", v, 32'h30);
        check("R8 masked pin pad", 32'(slew[43:42]), 3);
        wr(8'h40, 32'h10); check("R8 code1", 32'(slew[1:0]), 1);
        wr(8'h40, 32'h20); check("R8 code2", 32'(slew[1:0]), 2);
        wr(8'h4A, 32'h32);
        rd(8'h4A, v); check("R8 unmasked readback", v, 32'h02);
        check("R8 unmasked pad", 32'(slew[21:20]), 0);
        wr(8'h40, 32'h0); wr(8'h4A, 32'h0); wr(8'h55, 32'h0);
    endtask

    task automatic t_reserved();
        for (int f = 0; f < 16; f++) begin
            p_oe[6*16+f] = 1'b1; p_out[6*16+f] = 1'b1;
        end
        wr(8'h46, 32'h01);
        wr(8'h26, 32'hD);
        check("R9 selD oe", 32'(oe[6]), 0);
        check("R9 selD out", 32'(po[6]), 0);
        wr(8'h26, 32'hE);
        check("R9 selE oe", 32'(oe[6]), 0);
        check("R9 selE out", 32'(po[6]), 0);
        wr(8'h26, 32'hC);
        check("R9 selC drives", 32'(oe[6]), 1);
        wr(8'h46, 32'h00);
    endtask

    task automatic t_out_of_range();
        logic [31:0] v;
        wr(8'h58, 32'hFF);
        rd(8'h58, v); check("R10 cfg beyond", v, 0);
        rd(8'h57, v); check("R10 last pin untouched", v, 0);
        wr(8'h3E, 32'hF);
        rd(8'h3E, v); check("R10 sel beyond", v, 0);
        wr(8'h10, 32'hFFFF_FFFF);
        rd(8'h10, v); check("R10 unmapped", v, 0);
        check("R10 no pad change", 32'(oe), 32'(oe) & 32'h60);
        rd(8'h00, v); check("R10 dir untouched", v, 0);
    endtask

    task automatic t_latency();
        logic [31:0] v;
        wr(8'h44, 32'h84);
        rd(8'h40, v); check("R11 first read", v, 0);
        @(negedge clk); addr = 8'h44;
        #1; check("R11 not yet updated", rdata, 0);
        @(negedge clk); check("R11 after edge", rdata, 32'h84);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_cfg_layout();
        t_port_mode();
        t_periph_mode();
        t_pull();
        t_input_gate();
        t_mux_readback();
        t_slew();
        t_reserved();
        t_out_of_range();
        t_latency();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule